// File: doc/BRIEF.md
# Gated Timer with Single-Pulse Capture

A 16-bit up-counter that advances on a count tick, optionally qualified by an external gate. The raw gate is registered, optionally inverted, and optionally passed through a toggle stage that turns one full gate period into one long active window. The qualified level is reported at all times, whether or not gating is in use, and its falling edge raises a sticky interrupt flag that only software clears.

In single-pulse mode software arms the timer with a go pulse. The counter then advances only while the qualified gate is active, and the first falling edge of the qualified gate disarms the timer in hardware. Nothing more is counted until software arms it again. Single-pulse and toggle modes can be combined to capture exactly one period of the gate signal. The counter can be loaded synchronously, wraps from all ones to zero, and flags each wrap with a one-cycle pulse.

Top module: `pulse_gate_timer`

## Requirements
- R1: After reset the count, the overflow pulse, the armed flag and the interrupt flag are all 0, and with polarity low the gate level reads 0.
- R2: With gating disabled, every cycle with the tick high adds one to the count, whatever the gate input does.
- R3: With gating enabled and single-pulse mode off, the count advances on a tick only while the qualified gate level is 1.
- R4: In toggle mode the qualified level flips on each rising edge of the polarity-adjusted gate; with toggle mode off that internal toggle state is held at 0.
- R5: The armed flag is set one cycle after a go pulse while single-pulse mode is on, and reads 0 one cycle after any cycle in which single-pulse mode is off.
- R6: While single-pulse mode and gating are on and the armed flag is 0, gate pulses and ticks leave the count unchanged.
- R7: The falling edge of the qualified level clears the armed flag one cycle later, unless a go pulse arrives in that same cycle, in which case the flag stays set.
- R8: The interrupt flag is set one cycle after the qualified level falls and stays set until a clear pulse; a clear in the same cycle as a new falling edge leaves it set.
- R9: A tick at count 0xFFFF gives a count of 0x0000 and an overflow output high for exactly that one cycle.
- R10: A write loads the write data on the next edge and overrides an increment requested in the same cycle; a write of 0xFFFF never raises the overflow output.
- R11: The gate level output equals the registered gate input XOR the polarity bit (or the toggle state in toggle mode), one cycle after the input, even with gating disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count tick |
| gate_i | input | 1 | Raw gate input, synchronous to clk |
| gate_en_i | input | 1 | 1: counting is qualified by the gate |
| gate_pol_i | input | 1 | 1: gate is active low |
| tog_mode_i | input | 1 | 1: toggle stage enabled |
| sp_mode_i | input | 1 | 1: single-pulse mode enabled |
| go_set_i | input | 1 | Software pulse that arms single-pulse capture |
| irq_clr_i | input | 1 | Software pulse that clears the interrupt flag |
| cnt_wr_i | input | 1 | Synchronous count load strobe |
| cnt_wdata_i | input | 16 | Count load value |
| cnt_o | output | 16 | Current count |
| ovf_o | output | 1 | One-cycle pulse on wrap to zero |
| armed_o | output | 1 | Go/done flag: 1 while single-pulse capture is armed |
| gate_lvl_o | output | 1 | Current qualified gate level |
| irq_o | output | 1 | Sticky gate interrupt flag |

## Verification
Two pairs of functions can fall in the same cycle. A count load can coincide with an increment. A software go pulse can coincide with the hardware falling edge that disarms the timer. Directed sequences place the write on a tick at 0xFFFF, and the go pulse in the cycle right after the qualified gate drops. The expected count, overflow and armed flag are then compared with the winning action in R10 and R7. Random stimulus also produces both collisions and is judged each cycle against a bench reference model.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
  // Qualified gate as seen by the arming logic and the counter.
  typedef struct packed {
    logic level;  // current qualified gate level
    logic fall;   // qualified level dropped this cycle
  } gate_evt_t;

  localparam int unsigned PGT_CNT_W = 16;
endpackage

// File: rtl/pgt_gate_qual.sv
module pgt_gate_qual
  import pgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      gate_i,
  input  logic      pol_i,
  input  logic      tog_mode_i,
  output gate_evt_t evt_o
);
  logic gate_q;
  logic pol_gate;
  logic pol_prev_q, pol_prev_d;
  logic tog_q, tog_d;
  logic lvl_prev_q, lvl_prev_d;
  logic lvl;

  // Input register stage(s)
  generate
    if (SYNC_STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= gate_i;
      end
      assign gate_q = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], gate_i};
      end
      assign gate_q = s_q[SYNC_STAGES-1];
    end
  endgenerate

  assign pol_gate = gate_q ^ pol_i;
  assign lvl      = tog_mode_i ? tog_q : pol_gate;

  always_comb begin
    pol_prev_d = pol_gate;
    lvl_prev_d = lvl;
    if (!tog_mode_i)                 tog_d = 1'b0;
    else if (pol_gate && !pol_prev_q) tog_d = ~tog_q;
    else                             tog_d = tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_prev_q <= 1'b0;
      tog_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      pol_prev_q <= pol_prev_d;
      tog_q      <= tog_d;
      lvl_prev_q <= lvl_prev_d;
    end
  end

  assign evt_o.level = lvl;
  assign evt_o.fall  = lvl_prev_q & ~lvl;
endmodule

// File: rtl/pgt_arm.sv
module pgt_arm
  import pgt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  gate_evt_t evt_i,
  input  logic      sp_mode_i,
  input  logic      go_set_i,
  input  logic      irq_clr_i,
  output logic      armed_o,
  output logic      irq_o
);
  logic armed_q, armed_d;
  logic irq_q, irq_d;

  always_comb begin
    // software arm beats the hardware disarm in the same cycle
    if (!sp_mode_i)     armed_d = 1'b0;
    else if (go_set_i)  armed_d = 1'b1;
    else if (evt_i.fall) armed_d = 1'b0;
    else                armed_d = armed_q;

    // hardware set beats software clear
    if (evt_i.fall)     irq_d = 1'b1;
    else if (irq_clr_i) irq_d = 1'b0;
    else                irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign armed_o = armed_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pgt_counter.sv
module pgt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = wr_i | inc_i;
    cnt_d  = wr_i ? wdata_i : cnt_q + 1'b1;
    ovf_d  = inc_i & ~wr_i & (cnt_q == ALL_ONES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/pulse_gate_timer.sv
module pulse_gate_timer
  import pgt_pkg::*;
#(
  parameter int unsigned CNT_W       = PGT_CNT_W,
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             gate_en_i,
  input  logic             gate_pol_i,
  input  logic             tog_mode_i,
  input  logic             sp_mode_i,
  input  logic             go_set_i,
  input  logic             irq_clr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             armed_o,
  output logic             gate_lvl_o,
  output logic             irq_o
);
  gate_evt_t evt;
  logic      armed;
  logic      gate_ok;
  logic      inc;

  pgt_gate_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_i    (gate_i),
    .pol_i     (gate_pol_i),
    .tog_mode_i(tog_mode_i),
    .evt_o     (evt)
  );

  pgt_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt),
    .sp_mode_i(sp_mode_i),
    .go_set_i (go_set_i),
    .irq_clr_i(irq_clr_i),
    .armed_o  (armed),
    .irq_o    (irq_o)
  );

  always_comb begin
    gate_ok = evt.level & (~sp_mode_i | armed);
    inc     = tick_i & (~gate_en_i | gate_ok);
  end

  pgt_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (inc),
    .wr_i   (cnt_wr_i),
    .wdata_i(cnt_wdata_i),
    .cnt_o  (cnt_o),
    .ovf_o  (ovf_o)
  );

  assign armed_o    = armed;
  assign gate_lvl_o = evt.level;
endmodule

// File: rtl/pgt_checker.sv
module pgt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             gate_en_i,
  input logic             sp_mode_i,
  input logic             irq_clr_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ovf_o,
  input logic             armed_o,
  input logic             irq_o
);
  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_o == $past(cnt_wdata_i));

  // R9
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (cnt_o == '0) && ($past(cnt_o) == {CNT_W{1'b1}}));

  // R5
  disarm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_mode_i |=> !armed_o);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_mode_i && gate_en_i && !armed_o && !cnt_wr_i) |=> $stable(cnt_o));

  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en_i && tick_i && !cnt_wr_i) |=> cnt_o == $past(cnt_o) + 1'b1);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

bind pulse_gate_timer pgt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .gate_en_i  (gate_en_i),
  .sp_mode_i  (sp_mode_i),
  .irq_clr_i  (irq_clr_i),
  .cnt_wr_i   (cnt_wr_i),
  .cnt_wdata_i(cnt_wdata_i),
  .cnt_o      (cnt_o),
  .ovf_o      (ovf_o),
  .armed_o    (armed_o),
  .irq_o      (irq_o)
);

// File: tb/pulse_gate_timer_tb.sv
`timescale 1ns/1ps
module pulse_gate_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, gate, gen, pol, tog, sp, go, iclr, wr;
  logic [15:0] wdata;
  logic [15:0] cnt;
  logic        ovf, armed, lvl, irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  pulse_gate_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate),
    .gate_en_i(gen), .gate_pol_i(pol), .tog_mode_i(tog), .sp_mode_i(sp),
    .go_set_i(go), .irq_clr_i(iclr), .cnt_wr_i(wr), .cnt_wdata_i(wdata),
    .cnt_o(cnt), .ovf_o(ovf), .armed_o(armed), .gate_lvl_o(lvl), .irq_o(irq)
  );

  // Reference model state
  logic        m_gq, m_pprev, m_tog, m_lprev, m_arm, m_irq, m_ovf;
  logic [15:0] m_cnt;

  function automatic logic m_level(logic gq, logic t, logic p, logic tm);
    return tm ? t : (gq ^ p);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " cnt"},   {16'd0, cnt}, {16'd0, m_cnt});
    check({tag, " ovf"},   {31'd0, ovf}, {31'd0, m_ovf});
    check({tag, " armed"}, {31'd0, armed}, {31'd0, m_arm});
    check({tag, " lvl R11"}, {31'd0, lvl}, {31'd0, m_level(m_gq, m_tog, pol, tog)});
    check({tag, " irq"},   {31'd0, irq}, {31'd0, m_irq});
  endtask

  // One clock: model next state from pre-edge inputs, then compare after the edge.
  task automatic step(input string tag);
    logic pg, l, fall, inc;
    logic n_tog, n_arm, n_irq, n_ovf;
    logic [15:0] n_cnt;
    pg   = m_gq ^ pol;
    l    = m_level(m_gq, m_tog, pol, tog);
    fall = m_lprev & ~l;
    n_tog = !tog ? 1'b0 : ((pg && !m_pprev) ? ~m_tog : m_tog);
    n_arm = !sp ? 1'b0 : (go ? 1'b1 : (fall ? 1'b0 : m_arm));
    n_irq = fall ? 1'b1 : (iclr ? 1'b0 : m_irq);
    inc   = tick && (!gen || (l && (!sp || m_arm)));
    n_cnt = wr ? wdata : (inc ? m_cnt + 16'd1 : m_cnt);
    n_ovf = inc && !wr && (m_cnt == 16'hFFFF);
    @(posedge clk);
    #1;
    m_gq = gate; m_pprev = pg; m_tog = n_tog; m_lprev = l;
    m_arm = n_arm; m_irq = n_irq; m_cnt = n_cnt; m_ovf = n_ovf;
    compare_all(tag);
  endtask

  task automatic idle_inputs();
    tick = 0; gate = 0; gen = 0; pol = 0; tog = 0; sp = 0;
    go = 0; iclr = 0; wr = 0; wdata = 16'h0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1357));
    idle_inputs();
    rst_n = 0;
    m_gq = 0; m_pprev = 0; m_tog = 0; m_lprev = 0;
    m_arm = 0; m_irq = 0; m_ovf = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 cnt", {16'd0, cnt}, 32'd0);
    check("R1 flags", {28'd0, ovf, armed, irq, lvl}, 32'd0);
    rst_n = 1;

    // R2 free running, gate wiggles
    tick = 1;
    for (int i = 0; i < 5; i++) begin gate = i[0]; step("R2"); end
    check("R2 count five", {16'd0, cnt}, 32'd5);

    // R10 write beats increment
    wr = 1; wdata = 16'h1234; step("R10");
    check("R10 load", {16'd0, cnt}, 32'h1234);
    // R9 wrap
    wdata = 16'hFFFF; step("R10");
    check("R10 no ovf on load", {31'd0, ovf}, 32'd0);
    wr = 0; step("R9");
    check("R9 wrap", {16'd0, cnt}, 32'd0);
    check("R9 ovf high", {31'd0, ovf}, 32'd1);
    tick = 0; step("R9");
    check("R9 ovf one cycle", {31'd0, ovf}, 32'd0);

    // R11 level with gating off, and polarity
    gate = 1; step("R11");
    check("R11 level", {31'd0, lvl}, 32'd1);
    pol = 1; #1;
    check("R11 inverted", {31'd0, lvl}, 32'd0);
    pol = 0; gate = 0; step("R11"); step("R8");
    check("R8 irq after fall", {31'd0, irq}, 32'd1);
    iclr = 1; step("R8"); iclr = 0;
    check("R8 cleared", {31'd0, irq}, 32'd0);

    // R3 gated counting
    gen = 1; tick = 1; wr = 1; wdata = 16'd0; step("R10"); wr = 0;
    step("R3"); step("R3");
    check("R3 held gate low", {16'd0, cnt}, 32'd0);
    gate = 1; step("R3"); step("R3"); step("R3");
    check("R3 counted", {16'd0, cnt}, 32'd2);
    gate = 0; step("R3"); step("R3");

    // R4 toggle mode
    tog = 1;
    for (int i = 0; i < 8; i++) begin gate = i[1]; step("R4"); end
    tog = 0; step("R4");

    // R5/R6/R7 single pulse
    sp = 1; tick = 1; gate = 0; step("R6"); step("R6");
    check("R6 not armed no count", {31'd0, armed}, 32'd0);
    go = 1; step("R5"); go = 0;
    check("R5 armed", {31'd0, armed}, 32'd1);
    gate = 1; step("R6"); step("R6"); step("R6");
    gate = 0; step("R7");
    go = 1; step("R7"); go = 0;
    check("R7 set beats fall", {31'd0, armed}, 32'd1);
    gate = 1; step("R7"); gate = 0; step("R7"); step("R7");
    check("R7 disarmed", {31'd0, armed}, 32'd0);
    for (int i = 0; i < 6; i++) begin gate = i[1]; step("R6"); end
    go = 1; step("R5"); go = 0; sp = 0; step("R5");
    check("R5 mode off clears", {31'd0, armed}, 32'd0);
    // toggle plus single pulse: one period
    tog = 1; sp = 1; go = 1; step("R4"); go = 0;
    for (int i = 0; i < 12; i++) begin gate = (i % 4) < 2; step("R7"); end

    // Random phase
    idle_inputs();
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 4) != 0;
      gate = ($urandom % 3) == 0 ? ~gate : gate;
      if (($urandom % 50) == 0) gen = ~gen;
      if (($urandom % 80) == 0) pol = ~pol;
      if (($urandom % 60) == 0) tog = ~tog;
      if (($urandom % 40) == 0) sp = ~sp;
      go    = ($urandom % 16) == 0;
      iclr  = ($urandom % 8) == 0;
      wr    = ($urandom % 32) == 0;
      wdata = (($urandom % 2) == 0) ? 16'hFFFF - 16'($urandom % 3) : 16'($urandom);
      step("R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule